// File: doc/BRIEF.md
# Manual-Reset-Qualified System Reset Generator

This block drives the active-low system reset of a chip region. It takes two causes for reset. One is a digital supply-good level. The other is an active-low manual reset line, which may come from a push button or from a watchdog fault output wired back to it. As soon as either cause is present, reset is driven low. After both causes have gone away, reset stays low for a fixed hold time. If either cause comes back during that hold time, the hold count starts again from zero. The block leaves its own asynchronous reset with the system reset low and runs one full hold time before it releases it.

The manual reset line is first passed through a synchronizer. It is then qualified: a low level only counts once it has been seen for a minimum number of consecutive clock samples, so shorter glitches are discarded. The qualified level is also exported as a flag. A watchdog uses this flag to clear its timer and drop its fault pulse. Every duration is a cycle-count parameter: `HOLD_CYC` for the hold time, `MR_MIN_CYC` for the minimum manual-reset width, and `SYNC_STAGES` for the synchronizer depth.

Top module: `sys_reset_gen`

## Requirements
- R1: When `supply_ok_i` is sampled low at a clock edge, `rst_no` is low after that same edge.
- R2: `rst_no` goes low on the edge after `mr_active_o` goes high, and stays low for as long as `mr_active_o` stays high.
- R3: Once both causes are absent (`supply_ok_i` high and `mr_active_o` low), `rst_no` goes high on the `HOLD_CYC`-th consecutive edge at which no cause is sampled. For a supply-low stretch of D samples, this makes `rst_no` low for exactly D+HOLD_CYC-1 cycles.
- R4: If a cause is sampled again before `rst_no` has gone high, the hold count restarts. A one-sample supply drop followed by a second one G edges later (G < HOLD_CYC) keeps `rst_no` low for G+HOLD_CYC cycles.
- R5: A low stretch on `mr_ni` that lasts fewer than `MR_MIN_CYC` consecutive samples never raises `mr_active_o` and never pulls `rst_no` low.
- R6: A low stretch on `mr_ni` of N >= `MR_MIN_CYC` samples raises `mr_active_o` for exactly N-MR_MIN_CYC+1 cycles. It rises `SYNC_STAGES`+MR_MIN_CYC-1 edges after the first low sample.
- R7: While `rst_ni` is low, `rst_no` and `mr_active_o` are low. After `rst_ni` is released with no cause present, `rst_no` stays low for exactly HOLD_CYC-1 sampled cycles and then goes high.
- R8: `mr_ni` held high (inactive) has no effect: with supply good, `rst_no` stays high and `mr_active_o` stays low.
- R9: A qualified manual reset of N samples, for example a looped-back fault pulse much longer than `MR_MIN_CYC`, keeps `rst_no` low for N+HOLD_CYC-MR_MIN_CYC cycles, which always includes a full hold time after the flag drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block itself |
| supply_ok_i | input | 1 | Supply-good level, synchronous to clk_i, high means good |
| mr_ni | input | 1 | Asynchronous active-low manual reset request |
| rst_no | output | 1 | Active-low system reset |
| mr_active_o | output | 1 | High while a qualified manual reset is held |

## Verification
The assertions assume that `supply_ok_i` is already synchronous to `clk_i`, since it is used without a synchronizer. The bench therefore changes it only just after a falling clock edge. `mr_ni` may change at any time, but the bench also drives it at falling edges. This makes the number of consecutive low samples equal to the pulse length written in the test, and the expected low-cycle counts follow directly from the R5, R6 and R9 formulas. Each stimulus is given a settling window longer than the hold time, so every measurement starts from a released reset.

// File: rtl/sys_reset_pkg.sv
package sys_reset_pkg;
  localparam int unsigned DEF_HOLD_CYC    = 10_000_000;
  localparam int unsigned DEF_MR_MIN_CYC  = 100;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[g] <= RST_VAL;
        else         sh_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[g] <= RST_VAL;
        else         sh_q[g] <= sh_q[g-1];
    end
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/srg_mr_qual.sv
module srg_mr_qual
  import sys_reset_pkg::*;
#(
  parameter int unsigned MIN_CYC = DEF_MR_MIN_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_low_i,
  output logic active_o
);
  localparam int unsigned CW = cnt_w(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  // count consecutive low samples; flag once the minimum width is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!mr_low_i) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (cnt_q == LAST) active_q <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;

  AST_MR_RISE_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(mr_low_i)); // R6
  AST_MR_HIGH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_low_i |=> !active_q); // R5
  AST_MR_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
endmodule

// File: rtl/srg_hold_timer.sv
module srg_hold_timer
  import sys_reset_pkg::*;
#(
  parameter int unsigned HOLD_CYC = DEF_HOLD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic rel_o
);
  localparam int unsigned CW = cnt_w(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  // any cause restarts the hold from zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (cause_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) rel_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rel_o = rel_q;

  AST_CAUSE_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> !rel_q); // R4
  AST_RISE_AFTER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> !$past(cause_i)); // R3
  AST_RELEASE_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_q && !cause_i) |=> rel_q); // R3
  AST_HOLD_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/sys_reset_gen.sv
module sys_reset_gen
  import sys_reset_pkg::*;
#(
  parameter int unsigned HOLD_CYC    = DEF_HOLD_CYC,
  parameter int unsigned MR_MIN_CYC  = DEF_MR_MIN_CYC,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  output logic rst_no,
  output logic mr_active_o
);
  logic mr_sync;
  logic mr_active;
  logic cause;

  // idle level 1: manual reset inactive through reset
  srg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mr_ni),
    .q_o   (mr_sync)
  );

  srg_mr_qual #(.MIN_CYC(MR_MIN_CYC)) u_mr_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mr_low_i(~mr_sync),
    .active_o(mr_active)
  );

  assign cause = ~supply_ok_i | mr_active;

  srg_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(cause),
    .rel_o  (rst_no)
  );

  assign mr_active_o = mr_active;

  AST_SUPPLY_LOW_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !rst_no); // R1
  AST_MR_FORCES_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_active_o |=> !rst_no); // R2
  AST_IN_RESET_LOW: assert property (@(posedge clk_i)
    !rst_ni |-> (!rst_no && !mr_active_o)); // R7
endmodule

// File: tb/sys_reset_gen_tb_top.sv
module sys_reset_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 8;
  localparam int MRMIN = 4;
  localparam int SYNC = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok_i = 1'b1;
  logic mr_ni = 1'b1;
  logic rst_no, mr_active_o;

  int n_chk = 0;
  int n_err = 0;
  int low_cnt = 0;
  int act_cnt = 0;
  bit done = 1'b0;

  sys_reset_gen #(.HOLD_CYC(HOLD), .MR_MIN_CYC(MRMIN), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i), .mr_ni(mr_ni),
    .rst_no(rst_no), .mr_active_o(mr_active_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    if (!rst_no) low_cnt++;
    if (mr_active_o) act_cnt++;
  endtask

  task automatic clear();
    low_cnt = 0;
    act_cnt = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R7 reset state and power-on hold
    repeat (3) @(negedge clk_i);
    check("R7 rst_no in reset", int'(rst_no), 0);
    check("R7 mr_active in reset", int'(mr_active_o), 0);
    rst_ni = 1'b1;
    clear();
    repeat (HOLD + 5) tick();
    check("R7 power-on low cycles", low_cnt, HOLD - 1);
    check("R7 released", int'(rst_no), 1);

    // R8 idle manual reset has no effect
    clear();
    repeat (40) tick();
    check("R8 idle low cycles", low_cnt, 0);
    check("R8 idle mr_active", act_cnt, 0);

    // R1 R3 supply drop sweep
    for (int d = 1; d <= 5; d++) begin
      clear();
      supply_ok_i = 1'b0;
      tick();
      check("R1 low after first edge", int'(rst_no), 0);
      repeat (d - 1) tick();
      supply_ok_i = 1'b1;
      repeat (HOLD + 6) tick();
      check("R3 supply hold cycles", low_cnt, d + HOLD - 1);
    end

    // R4 restart during hold
    for (int g = 2; g < HOLD; g += 2) begin
      clear();
      supply_ok_i = 1'b0;
      tick();
      supply_ok_i = 1'b1;
      repeat (g - 1) tick();
      supply_ok_i = 1'b0;
      tick();
      supply_ok_i = 1'b1;
      repeat (HOLD + 6) tick();
      check("R4 restart low cycles", low_cnt, g + HOLD);
    end

    // R5 R6 R2 manual reset width sweep
    for (int n = 1; n <= MRMIN + 3; n++) begin
      int rise_at;
      clear();
      rise_at = 0;
      mr_ni = 1'b0;
      for (int k = 1; k <= n; k++) begin
        tick();
        if (mr_active_o && rise_at == 0) rise_at = k;
      end
      mr_ni = 1'b1;
      for (int k = n + 1; k <= n + HOLD + SYNC + 8; k++) begin
        tick();
        if (mr_active_o && rise_at == 0) rise_at = k;
      end
      if (n < MRMIN) begin
        check("R5 glitch mr_active", act_cnt, 0);
        check("R5 glitch low cycles", low_cnt, 0);
      end else begin
        check("R6 mr_active cycles", act_cnt, n - MRMIN + 1);
        check("R6 rise edge", rise_at, SYNC + MRMIN);
        check("R2 mr low cycles", low_cnt, n + HOLD - MRMIN);
      end
    end

    // R9 long looped-back pulse
    clear();
    mr_ni = 1'b0;
    repeat (3 * MRMIN + 5) tick();
    mr_ni = 1'b1;
    repeat (HOLD + SYNC + 8) tick();
    check("R9 long pulse low cycles", low_cnt, 3 * MRMIN + 5 + HOLD - MRMIN);
    check("R9 released", int'(rst_no), 1);

    finish_run();
  end
endmodule